// File: doc/BRIEF.md
# Circular Data Table Pointer Manager

This block decides which data buffer in shared memory serves each bus message. A message is identified by a key. In terminal mode the key is the terminal address, the transmit/receive bit and the subaddress. In controller mode the key is a message number. Each key owns an entry that holds three table numbers (a first, a last and a current) and a block-mode enable. When a message starts, the current number of its key is returned one clock later. The block also gives the word address where that table begins in the shared buffer area.

In block mode each key walks a circular range of tables. A message that completes without error moves the key's current number forward by one. The number that follows the last table is the first table again. A message that fails leaves the pointer where it is, and so does any message on a key that has block mode off. A host port rewrites a whole entry in one write.

There is one write path into the entry table. A host write therefore takes precedence over a completion that arrives in the same cycle, and that completion is carried out on the following cycle, against the entry as the host left it. The word transfers and the memory data path lie outside this block.

Top module: `tbl_ring_mgr`

## Requirements
- R1: After reset, `tbl_valid_o` is 0 and every entry is zero, so a lookup of any key returns table number 0.
- R2: A one-cycle pulse on `lk_valid_i` is followed on the next clock by exactly one cycle of `tbl_valid_o` = 1, with `tbl_num_o` holding the current number of the looked-up key.
- R3: Each terminal key {address, transmit/receive bit, subaddress} selects its own entry, and the transmit/receive bit alone separates two keys. Controller message numbers use a space of entries apart from every terminal key, so message 0 and terminal key 0/0/0 are different entries.
- R4: `tbl_base_o` equals `tbl_num_o` multiplied by 32, the number of words in one table.
- R5: A `done_i` pulse with `done_err_i` = 0 applies to the key of the most recent lookup. If that entry has block mode enabled, its current number becomes current + 1.
- R6: When current equals last, a successful completion loads current with first. This includes a range of a single table (first = last) and a range that ends at table 1023.
- R7: When the entry's block-mode enable is 0, a successful completion leaves current unchanged.
- R8: A completion with `done_err_i` = 1 leaves current unchanged.
- R9: A host write (`hst_we_i` = 1) replaces the enable, first, last and current numbers of the addressed key together. A lookup in any later cycle returns the new current number.
- R10: A successful completion in the same cycle as a host write is carried out one cycle later, on the entry as written by the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Message start: look up the key below |
| lk_bc_mode_i | input | 1 | 1 = controller-mode key, 0 = terminal key |
| lk_rt_addr_i | input | 5 | Terminal address of the lookup key |
| lk_tr_i | input | 1 | Transmit/receive bit of the lookup key |
| lk_sa_i | input | 5 | Subaddress of the lookup key |
| lk_msg_i | input | 8 | Message number of the lookup key |
| done_i | input | 1 | Message completion pulse for the last looked-up key |
| done_err_i | input | 1 | Completion ended in error |
| hst_we_i | input | 1 | Host entry write strobe |
| hst_bc_mode_i | input | 1 | Host key mode |
| hst_rt_addr_i | input | 5 | Host key terminal address |
| hst_tr_i | input | 1 | Host key transmit/receive bit |
| hst_sa_i | input | 5 | Host key subaddress |
| hst_msg_i | input | 8 | Host key message number |
| hst_blk_en_i | input | 1 | Block-mode enable to store |
| hst_first_i | input | 10 | First table number to store |
| hst_last_i | input | 10 | Last table number to store |
| hst_cur_i | input | 10 | Current table number to store |
| tbl_valid_o | output | 1 | Lookup result valid |
| tbl_num_o | output | 10 | Current table number of the looked-up key |
| tbl_base_o | output | 15 | Word address of that table |

## Verification
The bench walks several rings until they wrap, including a single-table ring and a ring whose last table is 1023. A design that only increments would run past last, and an adder that stops at the range edge would stick. Failed completions and keys with block mode off are checked by looking up the same key again. A design that advances on them returns a number one higher than expected. Keys that differ only in the transmit/receive bit, and controller message 0 against terminal key 0/0/0, are used to catch an aliasing index. A host write that coincides with a completion must give the host's value plus one. A design that drops the completion, or applies it before the host write, returns the host's value unchanged.

// File: rtl/tbl_ring_pkg.sv
package tbl_ring_pkg;
  localparam int NUM_TABLES = 1024;
  localparam int TBL_W      = $clog2(NUM_TABLES);
  localparam int TBL_WORDS  = 32;
  localparam int WORD_OFS_W = $clog2(TBL_WORDS);
  localparam int BASE_W     = TBL_W + WORD_OFS_W;

  typedef logic [TBL_W-1:0] tbl_t;

  typedef struct packed {
    logic blk_en;
    tbl_t first;
    tbl_t last;
    tbl_t cur;
  } entry_t;
endpackage

// File: rtl/tbl_key_map.sv
module tbl_key_map #(
  parameter int RT_ADDR_W = 5,
  parameter int SA_W      = 5,
  parameter int MSG_W     = 8,
  parameter int IDX_W     = 12
) (
  input  logic                 bc_mode_i,
  input  logic [RT_ADDR_W-1:0] rt_addr_i,
  input  logic                 tr_i,
  input  logic [SA_W-1:0]      sa_i,
  input  logic [MSG_W-1:0]     msg_i,
  output logic [IDX_W-1:0]     idx_o
);
  localparam int RT_KEY_W = RT_ADDR_W + 1 + SA_W;
  localparam int RT_KEYS  = 1 << RT_KEY_W;

  logic [RT_KEY_W-1:0] rt_key;
  assign rt_key = {rt_addr_i, tr_i, sa_i};

  // controller keys sit above the whole terminal key space
  assign idx_o = bc_mode_i ? IDX_W'(RT_KEYS) + IDX_W'(msg_i) : IDX_W'(rt_key);
endmodule

// File: rtl/tbl_step.sv
module tbl_step
  import tbl_ring_pkg::*;
(
  input  tbl_t cur_i,
  input  tbl_t first_i,
  input  tbl_t last_i,
  output tbl_t nxt_o
);
  tbl_t inc;
  assign inc   = cur_i + tbl_t'(1);
  assign nxt_o = (cur_i == last_i) ? first_i : inc;
endmodule

// File: rtl/tbl_entry_store.sv
module tbl_entry_store
  import tbl_ring_pkg::*;
#(
  parameter int DEPTH = 2304,
  parameter int IDX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hst_we_i,
  input  logic [IDX_W-1:0] hst_idx_i,
  input  entry_t           hst_data_i,
  input  logic             adv_we_i,
  input  logic [IDX_W-1:0] adv_idx_i,
  input  tbl_t             adv_cur_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  output tbl_t             lk_cur_o,
  input  logic [IDX_W-1:0] act_idx_i,
  output entry_t           act_o
);
  entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (hst_we_i) begin
      mem_q[hst_idx_i] <= hst_data_i;
    end else if (adv_we_i) begin
      mem_q[adv_idx_i].cur <= adv_cur_i;
    end
  end

  assign lk_cur_o = mem_q[lk_idx_i].cur;
  assign act_o    = mem_q[act_idx_i];

  // single write path: caller must never issue both writes at once
  p_one_writer_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hst_we_i, adv_we_i}));
endmodule

// File: rtl/tbl_ring_mgr.sv
module tbl_ring_mgr
  import tbl_ring_pkg::*;
#(
  parameter int RT_ADDR_W = 5,
  parameter int SA_W      = 5,
  parameter int MSG_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lk_valid_i,
  input  logic                 lk_bc_mode_i,
  input  logic [RT_ADDR_W-1:0] lk_rt_addr_i,
  input  logic                 lk_tr_i,
  input  logic [SA_W-1:0]      lk_sa_i,
  input  logic [MSG_W-1:0]     lk_msg_i,
  input  logic                 done_i,
  input  logic                 done_err_i,
  input  logic                 hst_we_i,
  input  logic                 hst_bc_mode_i,
  input  logic [RT_ADDR_W-1:0] hst_rt_addr_i,
  input  logic                 hst_tr_i,
  input  logic [SA_W-1:0]      hst_sa_i,
  input  logic [MSG_W-1:0]     hst_msg_i,
  input  logic                 hst_blk_en_i,
  input  logic [TBL_W-1:0]     hst_first_i,
  input  logic [TBL_W-1:0]     hst_last_i,
  input  logic [TBL_W-1:0]     hst_cur_i,
  output logic                 tbl_valid_o,
  output logic [TBL_W-1:0]     tbl_num_o,
  output logic [BASE_W-1:0]    tbl_base_o
);
  localparam int RT_KEY_W = RT_ADDR_W + 1 + SA_W;
  localparam int RT_KEYS  = 1 << RT_KEY_W;
  localparam int MSG_KEYS = 1 << MSG_W;
  localparam int DEPTH    = RT_KEYS + MSG_KEYS;
  localparam int IDX_W    = $clog2(DEPTH);

  logic [IDX_W-1:0] lk_idx, hst_idx, act_idx_q;
  tbl_t             lk_cur, nxt_cur, tbl_num_q;
  entry_t           act_ent, hst_ent;
  logic             tbl_valid_q, pend_q, adv_req, adv_we;

  tbl_key_map #(
    .RT_ADDR_W(RT_ADDR_W), .SA_W(SA_W), .MSG_W(MSG_W), .IDX_W(IDX_W)
  ) i_lk_map (
    .bc_mode_i (lk_bc_mode_i),
    .rt_addr_i (lk_rt_addr_i),
    .tr_i      (lk_tr_i),
    .sa_i      (lk_sa_i),
    .msg_i     (lk_msg_i),
    .idx_o     (lk_idx)
  );

  tbl_key_map #(
    .RT_ADDR_W(RT_ADDR_W), .SA_W(SA_W), .MSG_W(MSG_W), .IDX_W(IDX_W)
  ) i_hst_map (
    .bc_mode_i (hst_bc_mode_i),
    .rt_addr_i (hst_rt_addr_i),
    .tr_i      (hst_tr_i),
    .sa_i      (hst_sa_i),
    .msg_i     (hst_msg_i),
    .idx_o     (hst_idx)
  );

  assign hst_ent = '{blk_en: hst_blk_en_i, first: hst_first_i,
                     last: hst_last_i, cur: hst_cur_i};

  // completion request: fresh successful done, or one deferred by a host write
  assign adv_req = (done_i & ~done_err_i) | pend_q;
  assign adv_we  = adv_req & ~hst_we_i & act_ent.blk_en;

  tbl_step i_step (
    .cur_i   (act_ent.cur),
    .first_i (act_ent.first),
    .last_i  (act_ent.last),
    .nxt_o   (nxt_cur)
  );

  tbl_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hst_we_i   (hst_we_i),
    .hst_idx_i  (hst_idx),
    .hst_data_i (hst_ent),
    .adv_we_i   (adv_we),
    .adv_idx_i  (act_idx_q),
    .adv_cur_i  (nxt_cur),
    .lk_idx_i   (lk_idx),
    .lk_cur_o   (lk_cur),
    .act_idx_i  (act_idx_q),
    .act_o      (act_ent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_valid_q <= 1'b0;
      tbl_num_q   <= '0;
      act_idx_q   <= '0;
      pend_q      <= 1'b0;
    end else begin
      tbl_valid_q <= lk_valid_i;
      pend_q      <= adv_req & hst_we_i;
      if (lk_valid_i) begin
        tbl_num_q <= lk_cur;
        act_idx_q <= lk_idx;
      end
    end
  end

  assign tbl_valid_o = tbl_valid_q;
  assign tbl_num_o   = tbl_num_q;
  assign tbl_base_o  = {tbl_num_q, {WORD_OFS_W{1'b0}}};

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> tbl_valid_o);
  p_valid_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !tbl_valid_o);
  p_err_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && done_err_i && !pend_q) |-> !adv_we);
  p_defer_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_we_i && done_i && !done_err_i) |=> pend_q);
  p_host_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hst_we_i |-> !adv_we);
endmodule

// File: tb/test_tbl_ring_mgr.sv
`timescale 1ns/1ps
module test_tbl_ring_mgr;
  localparam int OP_HW = 0, OP_LK = 1, OP_DN = 2, OP_DE = 3;

  typedef struct packed {
    logic [1:0] op;
    logic       bc;
    logic [4:0] rt;
    logic       tr;
    logic [4:0] sa;
    logic [7:0] msg;
    logic       blk;
    logic [9:0] first;
    logic [9:0] last;
    logic [9:0] cur;   // stored value for OP_HW, expected value for OP_LK
    logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{OP_HW, 0, 3, 0, 2, 0, 1, 10, 12, 10, 9},     // R9
    '{OP_LK, 0, 3, 0, 2, 0, 0, 0, 0, 10, 2},       // R2
    '{OP_DN, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5},
    '{OP_LK, 0, 3, 0, 2, 0, 0, 0, 0, 11, 5},       // R5
    '{OP_DN, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5},
    '{OP_LK, 0, 3, 0, 2, 0, 0, 0, 0, 12, 5},
    '{OP_DN, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6},
    '{OP_LK, 0, 3, 0, 2, 0, 0, 0, 0, 10, 6},       // R6 wrap
    '{OP_DE, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8},
    '{OP_LK, 0, 3, 0, 2, 0, 0, 0, 0, 10, 8},       // R8
    '{OP_HW, 0, 3, 1, 2, 0, 0, 100, 200, 150, 9},
    '{OP_LK, 0, 3, 1, 2, 0, 0, 0, 0, 150, 3},      // R3 tr bit
    '{OP_DN, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7},
    '{OP_LK, 0, 3, 1, 2, 0, 0, 0, 0, 150, 7},      // R7
    '{OP_LK, 0, 3, 0, 2, 0, 0, 0, 0, 10, 3},       // R3 neighbour intact
    '{OP_HW, 1, 0, 0, 0, 0, 1, 1020, 1023, 1023, 9},
    '{OP_LK, 1, 0, 0, 0, 0, 0, 0, 0, 1023, 3},
    '{OP_DN, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6},
    '{OP_LK, 1, 0, 0, 0, 0, 0, 0, 0, 1020, 6},     // R6 top end
    '{OP_LK, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3},        // R3 msg 0 vs key 0/0/0
    '{OP_HW, 0, 31, 1, 31, 0, 1, 7, 7, 7, 9},
    '{OP_LK, 0, 31, 1, 31, 0, 0, 0, 0, 7, 4},      // R4 base
    '{OP_DN, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6},
    '{OP_LK, 0, 31, 1, 31, 0, 0, 0, 0, 7, 6},      // R6 single-table ring
    '{OP_HW, 0, 3, 0, 2, 0, 1, 10, 12, 11, 9},
    '{OP_LK, 0, 3, 0, 2, 0, 0, 0, 0, 11, 9}        // R9 rewrite mid-ring
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lk_valid = 0, lk_bc = 0, lk_tr = 0;
  logic [4:0] lk_rt = 0, lk_sa = 0;
  logic [7:0] lk_msg = 0;
  logic       done = 0, done_err = 0;
  logic       hst_we = 0, hst_bc = 0, hst_tr = 0, hst_blk = 0;
  logic [4:0] hst_rt = 0, hst_sa = 0;
  logic [7:0] hst_msg = 0;
  logic [9:0] hst_first = 0, hst_last = 0, hst_cur = 0;
  logic        tbl_valid;
  logic [9:0]  tbl_num;
  logic [14:0] tbl_base;

  int checks = 0;
  int errors = 0;
  bit fin = 0;

  always #4 clk = ~clk;

  tbl_ring_mgr i_tbl_ring_mgr (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid), .lk_bc_mode_i(lk_bc), .lk_rt_addr_i(lk_rt),
    .lk_tr_i(lk_tr), .lk_sa_i(lk_sa), .lk_msg_i(lk_msg),
    .done_i(done), .done_err_i(done_err),
    .hst_we_i(hst_we), .hst_bc_mode_i(hst_bc), .hst_rt_addr_i(hst_rt),
    .hst_tr_i(hst_tr), .hst_sa_i(hst_sa), .hst_msg_i(hst_msg),
    .hst_blk_en_i(hst_blk), .hst_first_i(hst_first), .hst_last_i(hst_last),
    .hst_cur_i(hst_cur),
    .tbl_valid_o(tbl_valid), .tbl_num_o(tbl_num), .tbl_base_o(tbl_base)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_host(input logic bc, input logic [4:0] rt, input logic tr,
                          input logic [4:0] sa, input logic [7:0] msg, input logic blk,
                          input logic [9:0] f, input logic [9:0] l, input logic [9:0] c);
    hst_bc = bc; hst_rt = rt; hst_tr = tr; hst_sa = sa; hst_msg = msg;
    hst_blk = blk; hst_first = f; hst_last = l; hst_cur = c;
  endtask

  task automatic host_wr(input logic bc, input logic [4:0] rt, input logic tr,
                         input logic [4:0] sa, input logic [7:0] msg, input logic blk,
                         input logic [9:0] f, input logic [9:0] l, input logic [9:0] c);
    set_host(bc, rt, tr, sa, msg, blk, f, l, c);
    hst_we = 1'b1;
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic lookup(input logic bc, input logic [4:0] rt, input logic tr,
                        input logic [4:0] sa, input logic [7:0] msg,
                        input int exp, input string req);
    lk_bc = bc; lk_rt = rt; lk_tr = tr; lk_sa = sa; lk_msg = msg;
    lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    check(tbl_valid == 1'b1, "R2 valid", int'(tbl_valid), 1);
    check(int'(tbl_num) == exp, req, int'(tbl_num), exp);
    check(int'(tbl_base) == exp * 32, "R4 base", int'(tbl_base), exp * 32);
  endtask

  task automatic complete(input logic err);
    done = 1'b1; done_err = err;
    @(negedge clk);
    done = 1'b0; done_err = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(tbl_valid == 1'b0, "R1 valid", int'(tbl_valid), 0);
    lookup(1'b1, 5'd0, 1'b0, 5'd0, 8'd5, 0, "R1 entry zero");
    @(negedge clk);
    // R2: valid lasts exactly one cycle
    check(tbl_valid == 1'b0, "R2 pulse", int'(tbl_valid), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec %0d", v.req, i);
      case (int'(v.op))
        OP_HW: host_wr(v.bc, v.rt, v.tr, v.sa, v.msg, v.blk, v.first, v.last, v.cur);
        OP_LK: lookup(v.bc, v.rt, v.tr, v.sa, v.msg, int'(v.cur), tag);
        OP_DN: complete(1'b0);
        default: complete(1'b1);
      endcase
    end

    // R10: completion colliding with host write to the same key
    host_wr(1'b0, 5'd5, 1'b0, 5'd5, 8'd0, 1'b1, 10'd40, 10'd42, 10'd40);
    lookup(1'b0, 5'd5, 1'b0, 5'd5, 8'd0, 40, "R10 setup");
    set_host(1'b0, 5'd5, 1'b0, 5'd5, 8'd0, 1'b1, 10'd40, 10'd42, 10'd41);
    hst_we = 1'b1; done = 1'b1;
    @(negedge clk);
    hst_we = 1'b0; done = 1'b0;
    @(negedge clk);
    lookup(1'b0, 5'd5, 1'b0, 5'd5, 8'd0, 42, "R10 deferred advance");

    // R7: disabled entry ignores a completion after a second lookup
    lookup(1'b0, 5'd3, 1'b1, 5'd2, 8'd0, 150, "R7 setup");
    complete(1'b0);
    complete(1'b0);
    lookup(1'b0, 5'd3, 1'b1, 5'd2, 8'd0, 150, "R7 repeated done");

    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule